// File: doc/BRIEF.md
# Tamper event flag and erase controller

This block watches three external tamper pins and decides what each event does. A rising edge on a pin, once it has passed a two-stage synchronizer, counts as an event. Each pin has a mode bit and an erase-suppress bit in a guard configuration register. An unmasked pin latches a sticky flag, and the flag holds off further detection on that pin until software clears it. A masked pin only raises the trigger and keeps its flag at zero, so every edge is seen. An accepted unmasked event also erases a file of eight 32-bit backup registers held inside the block, unless that pin's erase-suppress bit is set.

Software reaches the block over a single-cycle register bus. The bus has a write strobe, a byte address and write data, and read data is combinational from the address. Through it software sets the configuration, enables interrupts, reads and clears flags, reads and writes the backup file, and orders an erase on demand. The outputs are the flag vector, a one-cycle trigger pulse, a level interrupt request and a one-cycle erase strobe.

Top module: `tamper_guard`

## Requirements
- R1: After reset every register reads zero: configuration, interrupt enable, flags and all eight backup registers. trig_o, irq_o and erase_o are low.
- R2: The configuration register sits at address 0x00. Bits 18:16 are the mask bits for tampers 3..1. Bits 2:0 are the no-erase bits for tampers 3..1. Bit 23 is the erase command. Every other bit, and bit 23, reads as zero.
- R3: An event is a rising edge of a pin after two synchronizing flip-flops. A pin driven high before clock edge k causes trig_o to be high for exactly one cycle, starting just after edge k+2, when the event is accepted or the pin is masked.
- R4: For an unmasked pin, an event with its flag clear sets the flag at the same edge as the trigger. The flag stays set until software clears it. The status register at 0x08 shows flag n at bit n-1.
- R5: For an unmasked pin whose flag is set, a new event is ignored: no trigger and no erase.
- R6: For a masked pin, every event triggers and the flag never reads 1. Setting a mask bit clears that pin's flag at the next edge.
- R7: An event on a masked pin never erases the backup registers, whatever its no-erase bit.
- R8: An accepted unmasked event whose no-erase bit is 0 raises erase_o for one cycle at the same edge as the trigger. The backup registers read zero from the next edge on. With the no-erase bit at 1, no erase takes place.
- R9: Writing 1 to configuration bit 23 raises erase_o in the next cycle and clears all backup registers at the edge after that. Writing 0 there does nothing.
- R10: Writing to the clear register at 0x0C clears each flag whose data bit n-1 is 1. Bits written as 0 leave their flags unchanged.
- R11: irq_o is high exactly when some flag is set, its enable bit is set (register 0x04, bit n-1 for tamper n) and its mask bit is clear.
- R12: A bus write to a backup register made in a cycle where erase_o is high is lost. The erase wins.
- R13: Backup register m (0..7) is read and written at byte address 0x20 + 4*m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamp_in | input | 3 | Tamper pins, bit n-1 for tamper n, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| flag_o | output | 3 | Sticky tamper flags |
| trig_o | output | 1 | One-cycle trigger pulse for any triggering event |
| irq_o | output | 1 | Interrupt request |
| erase_o | output | 1 | One-cycle backup erase strobe |

## Verification
A pin change shows up in flag_o, trig_o and erase_o three edges after it is driven. The backup file reads zero one edge after erase_o, and a bus write takes effect at the next edge. The bench holds a reference model that steps once per rising edge with the same register delays. It compares every output and the read data at each falling edge, so a result that is early or late by one cycle is caught as a mismatch. Inputs change just after the falling edge, so each comparison sees stable state.

// File: rtl/tamp_pkg.sv
package tamp_pkg;
  localparam int unsigned NTAMP     = 3;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BKP_DEPTH = 8;
  localparam int unsigned ADDR_W    = 6;

  localparam int unsigned MASK_LSB  = 16;
  localparam int unsigned NOER_LSB  = 0;
  localparam int unsigned ERASE_BIT = 23;

  localparam logic [ADDR_W-1:0] OFS_CFG  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_BKP  = 6'h20;

  // Build the configuration readback word from its fields.
  function automatic logic [DATA_W-1:0] cfg_word(input logic [NTAMP-1:0] mask,
                                                 input logic [NTAMP-1:0] noer);
    logic [DATA_W-1:0] w;
    w = '0;
    w[MASK_LSB +: NTAMP] = mask;
    w[NOER_LSB +: NTAMP] = noer;
    return w;
  endfunction

  // Interrupt: a held flag that is enabled and not masked.
  function automatic logic irq_of(input logic [NTAMP-1:0] flags,
                                  input logic [NTAMP-1:0] ien,
                                  input logic [NTAMP-1:0] mask);
    return |(flags & ien & ~mask);
  endfunction
endpackage

// File: rtl/tamp_edge_sync.sv
module tamp_edge_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic st1, st2, last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1  <= 1'b0;
        st2  <= 1'b0;
        last <= 1'b0;
      end else begin
        st1  <= pin_i[g];
        st2  <= st1;
        last <= st2;
      end
    end
    assign edge_o[g] = st2 & ~last;
  end
endmodule

// File: rtl/tamp_event_ctrl.sv
module tamp_event_ctrl #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] noer_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] trig_o,
  output logic [N-1:0] accept_o,
  output logic         erase_hit_o
);
  logic [N-1:0] wipe;

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic pass;
    assign accept_o[g] = edge_i[g] & ~flag_o[g] & ~mask_i[g];
    assign pass        = edge_i[g] & mask_i[g];
    assign wipe[g]     = accept_o[g] & ~noer_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_o[g] <= 1'b0;
        trig_o[g] <= 1'b0;
      end else begin
        trig_o[g] <= accept_o[g] | pass;
        if (mask_i[g])        flag_o[g] <= 1'b0;
        else if (accept_o[g]) flag_o[g] <= 1'b1;
        else if (clr_i[g])    flag_o[g] <= 1'b0;
      end
    end
  end

  assign erase_hit_o = |wipe;
endmodule

// File: rtl/tamp_backup_file.sv
module tamp_backup_file #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              we_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DEPTH*DW-1:0] flat_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 word_q <= '0;
      else if (erase_i)                           word_q <= '0;
      else if (we_i && idx_i == IW'(g))           word_q <= wdata_i;
    end
    assign flat_o[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamp_pkg::*;
#(
  parameter int unsigned N_TAMP = tamp_pkg::NTAMP,
  parameter int unsigned DEPTH  = tamp_pkg::BKP_DEPTH,
  localparam int unsigned IW    = $clog2(DEPTH),
  localparam int unsigned DW    = tamp_pkg::DATA_W,
  localparam int unsigned AW    = tamp_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAMP-1:0] tamp_in,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [N_TAMP-1:0] flag_o,
  output logic              trig_o,
  output logic              irq_o,
  output logic              erase_o
);
  logic [N_TAMP-1:0] mask_q, noer_q, ien_q;
  logic [N_TAMP-1:0] edge_w, accept_w, trig_vec, clr_w;
  logic              hit_cfg, hit_ien, hit_clr, in_bkp;
  logic              sw_erase_w, erase_hit_w;
  logic [IW-1:0]     bkp_idx;
  logic [DEPTH*DW-1:0] bkp_flat;

  assign hit_cfg = bus_we && bus_addr == OFS_CFG;
  assign hit_ien = bus_we && bus_addr == OFS_IEN;
  assign hit_clr = bus_we && bus_addr == OFS_CLR;
  assign in_bkp  = bus_addr[1:0] == 2'b00 && bus_addr >= OFS_BKP &&
                   32'(bus_addr) < 32'(OFS_BKP) + 4 * DEPTH;
  assign bkp_idx = bus_addr[IW+1:2];

  assign sw_erase_w = hit_cfg & bus_wdata[ERASE_BIT];
  assign clr_w      = hit_clr ? bus_wdata[N_TAMP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      noer_q  <= '0;
      ien_q   <= '0;
      erase_o <= 1'b0;
    end else begin
      erase_o <= sw_erase_w | erase_hit_w;
      if (hit_cfg) begin
        mask_q <= bus_wdata[MASK_LSB +: N_TAMP];
        noer_q <= bus_wdata[NOER_LSB +: N_TAMP];
      end
      if (hit_ien) ien_q <= bus_wdata[N_TAMP-1:0];
    end
  end

  tamp_edge_sync #(.N(N_TAMP)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(tamp_in), .edge_o(edge_w)
  );

  tamp_event_ctrl #(.N(N_TAMP)) u_evt (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .mask_i(mask_q),
    .noer_i(noer_q), .clr_i(clr_w), .flag_o(flag_o), .trig_o(trig_vec),
    .accept_o(accept_w), .erase_hit_o(erase_hit_w)
  );

  tamp_backup_file #(.DEPTH(DEPTH), .DW(DW)) u_bkp (
    .clk(clk), .rst_n(rst_n), .erase_i(erase_o), .we_i(bus_we && in_bkp),
    .idx_i(bkp_idx), .wdata_i(bus_wdata), .flat_o(bkp_flat)
  );

  assign trig_o = |trig_vec;
  assign irq_o  = irq_of(flag_o, ien_q, mask_q);

  always_comb begin
    bus_rdata = '0;
    if (in_bkp) bus_rdata = bkp_flat[bkp_idx*DW +: DW];
    else begin
      unique case (bus_addr)
        OFS_CFG:  bus_rdata = cfg_word(mask_q, noer_q);
        OFS_IEN:  bus_rdata[N_TAMP-1:0] = ien_q;
        OFS_STAT: bus_rdata[N_TAMP-1:0] = flag_o;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tamp_guard_chk.sv
module tamp_guard_chk #(
  parameter int unsigned N  = 3,
  parameter int unsigned FW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  edge_w,
  input logic [N-1:0]  trig_vec,
  input logic [N-1:0]  flag_o,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  clr_w,
  input logic          sw_erase_w,
  input logic          erase_o,
  input logic [FW-1:0] bkp_flat
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    a_r3_trig_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      trig_vec[g] |-> $past(edge_w[g]));
    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag_o[g]) && !$past(clr_w[g]) && !$past(mask_q[g])) |-> flag_o[g]);
    a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag_o[g]) && !$past(mask_q[g])) |-> !trig_vec[g]);
    a_r6_masked_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mask_q[g]) |-> !flag_o[g]);
  end

  a_r9_cmd_erase: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_erase_w) |-> erase_o);
  a_r12_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(erase_o) |-> bkp_flat == '0);
endmodule

bind tamper_guard tamp_guard_chk #(.N(N_TAMP), .FW(DEPTH*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_w(edge_w), .trig_vec(trig_vec),
  .flag_o(flag_o), .mask_q(mask_q), .clr_w(clr_w), .sw_erase_w(sw_erase_w),
  .erase_o(erase_o), .bkp_flat(bkp_flat)
);

// File: tb/sim_tamper_guard.sv
`timescale 1ns/1ps
module sim_tamper_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tamp_in = '0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  flag_o;
  logic        trig_o, irq_o, erase_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  string scen = "R1";

  always #2 clk = ~clk;

  tamper_guard u0 (
    .clk(clk), .rst_n(rst_n), .tamp_in(tamp_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_o(flag_o), .trig_o(trig_o), .irq_o(irq_o), .erase_o(erase_o)
  );

  // Reference model: state after each rising edge
  bit [2:0]  m_s1, m_s2, m_pv, m_flag, m_mask, m_noer, m_ien;
  bit        m_trig, m_erase;
  bit [31:0] m_bkp [8];

  always @(posedge clk) begin
    bit [2:0] ev, clr;
    bit trig_n, erase_n;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pv = 0; m_flag = 0; m_mask = 0; m_noer = 0;
      m_ien = 0; m_trig = 0; m_erase = 0;
      foreach (m_bkp[k]) m_bkp[k] = 0;
    end else begin
      ev = m_s2 & ~m_pv;
      clr = (bus_we && bus_addr == 6'h0C) ? bus_wdata[2:0] : 3'b0;
      trig_n = 0;
      erase_n = bus_we && bus_addr == 6'h00 && bus_wdata[23];
      for (int i = 0; i < 3; i++) begin
        if (m_mask[i]) begin
          if (ev[i]) trig_n = 1;
          m_flag[i] = 0;
        end else if (!m_flag[i] && ev[i]) begin
          m_flag[i] = 1;
          trig_n = 1;
          if (!m_noer[i]) erase_n = 1;
        end else if (clr[i]) m_flag[i] = 0;
      end
      if (m_erase) foreach (m_bkp[k]) m_bkp[k] = 0;
      else if (bus_we && bus_addr >= 6'h20 && bus_addr[1:0] == 0)
        m_bkp[bus_addr[4:2]] = bus_wdata;
      if (bus_we && bus_addr == 6'h00) begin
        m_mask = bus_wdata[18:16];
        m_noer = bus_wdata[2:0];
      end
      if (bus_we && bus_addr == 6'h04) m_ien = bus_wdata[2:0];
      m_pv = m_s2; m_s2 = m_s1; m_s1 = tamp_in;
      m_trig = trig_n;
      m_erase = erase_n;
    end
  end

  function automatic bit [31:0] m_read(input bit [5:0] a);
    if (a >= 6'h20 && a[1:0] == 0) return m_bkp[a[4:2]];
    case (a)
      6'h00: return {13'b0, m_mask, 13'b0, m_noer};
      6'h04: return {29'b0, m_ien};
      6'h08: return {29'b0, m_flag};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (during %s) at cycle %0d: got %h expected %h", req, scen, cyc, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      chk("R4", 32'(flag_o), 32'(m_flag));
      chk("R3", 32'(trig_o), 32'(m_trig));
      chk("R8", 32'(erase_o), 32'(m_erase));
      chk("R11", 32'(irq_o), 32'(|(m_flag & m_ien & ~m_mask)));
      chk(bus_addr >= 6'h20 ? "R13" : "R2", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic wr(input bit [5:0] a, input bit [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input bit [5:0] a);
    bus_addr = a;
    step(1);
  endtask

  task automatic pulse(input int ch);
    tamp_in[ch] = 1; step(4);
    tamp_in[ch] = 0; step(5);
  endtask

  task automatic fill();
    for (int k = 0; k < 8; k++) wr(6'h20 + 6'(4*k), 32'hA500_0000 + 32'(k));
  endtask

  task automatic report();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    step(3);
    scen = "R1";
    chk("R1", bus_rdata, 32'h0);
    rd(6'h08); chk("R1", bus_rdata, 32'h0);
    rd(6'h3C); chk("R1", bus_rdata, 32'h0);
    rst_n = 1; step(2);

    scen = "R13";
    fill();
    rd(6'h24); chk("R13", bus_rdata, 32'hA500_0001);
    rd(6'h3C); chk("R13", bus_rdata, 32'hA500_0007);

    scen = "R2";
    wr(6'h00, 32'hFF7F_FFFF);
    rd(6'h00); chk("R2", bus_rdata, 32'h0007_0007);
    scen = "R9";
    chk("R9", 32'(erase_o), 32'h0);
    rd(6'h20); chk("R9", bus_rdata, 32'hA500_0000);
    wr(6'h00, 32'h0);

    scen = "R8";
    wr(6'h04, 32'h7);
    rd(6'h20);
    pulse(0);
    chk("R4", 32'(flag_o), 32'h1);
    chk("R8", bus_rdata, 32'h0);
    chk("R11", 32'(irq_o), 32'h1);

    scen = "R5";
    fill(); rd(6'h28);
    pulse(0);
    chk("R5", bus_rdata, 32'hA500_0002);

    scen = "R10";
    wr(6'h0C, 32'h6); chk("R10", 32'(flag_o), 32'h1);
    wr(6'h0C, 32'h1); chk("R10", 32'(flag_o), 32'h0);

    scen = "R8";
    wr(6'h00, 32'h0000_0002);
    rd(6'h2C);
    pulse(1);
    chk("R8", 32'(flag_o), 32'h2);
    chk("R8", bus_rdata, 32'hA500_0003);

    scen = "R6";
    wr(6'h00, 32'h0002_0002); step(1);
    chk("R6", 32'(flag_o), 32'h0);
    chk("R11", 32'(irq_o), 32'h0);

    scen = "R7";
    wr(6'h00, 32'h0004_0000);
    rd(6'h30);
    pulse(2); pulse(2);
    chk("R7", bus_rdata, 32'hA500_0004);
    chk("R6", 32'(flag_o), 32'h0);
    tamp_in = 3'b111; step(5); tamp_in = 0; step(5);

    scen = "R12";
    wr(6'h00, 32'h0080_0000);
    wr(6'h34, 32'h1234_5678);
    rd(6'h34); chk("R12", bus_rdata, 32'h0);
    wr(6'h34, 32'h1234_5678);
    rd(6'h34); chk("R13", bus_rdata, 32'h1234_5678);

    scen = "R10";
    wr(6'h00, 32'h0);
    pulse(0); pulse(2);
    wr(6'h0C, 32'h7); step(2);
    for (int a = 0; a < 64; a += 4) rd(6'(a));
    report();
  end
endmodule